// File: doc/BRIEF.md
# Hot-Swap Overcurrent Retry Controller

This block decides, cycle by cycle, whether the gate of an external pass transistor in a hot-swap power path may be driven on. It takes three digitized fault flags (overcurrent or hard short, undervoltage, overvoltage), a mode select and an active-high master reset. It produces a gate-enable and a latched alarm. After power-on it waits for all three flags to be clear, then enables the gate. An overcurrent drops the gate at once and starts a fixed back-off period, counted in clock ticks by a parameter sized for 100 ms. When that period ends, the gate is retried.

When the mode select is low, the block retries without end until the overcurrent goes away. When the mode select is high, it gives up after five failed retries. It then keeps the gate off and raises the alarm, which stays set until the master reset or the power-on reset. A turn-on that survives one full back-off period restores the whole retry budget.

Undervoltage and overvoltage force the gate off without using up retries. The block re-enables the gate as soon as both clear. All fault and mode inputs pass through a two-stage synchronizer before they are used.

Top module: `hsw_retry_ctrl`

## Requirements
- R1: gate_en is low in every cycle where any of oc_in, uv_in or ov_in was high two clock edges earlier. A flag raised while the gate is on drops gate_en two clock edges later.
- R2: An overcurrent seen while the gate is on moves the block into the back-off period, with the gate off. In limited mode with the retry budget spent, it moves into the locked state instead.
- R3: The back-off period lasts exactly WAIT_TICKS clock cycles. Then the gate is retried: gate_en rises at edge c+3+WAIT_TICKS for an overcurrent first driven after edge c and already cleared.
- R4: With limit_mode low (unlimited), overcurrent retries never raise fault_alarm. The gate comes on at the first retry that finds the overcurrent clear.
- R5: With limit_mode high (limited), a continuous overcurrent first driven after edge c raises fault_alarm at edge c+5*WAIT_TICKS+8, which is the fifth failed retry. From then on gate_en stays low, even after the overcurrent clears.
- R6: mreset high at a clock edge clears fault_alarm and gate_en at that edge and returns the block to idle. If the flags are clear, gate_en rises at the first edge after mreset falls.
- R7: A retry that finds no overcurrent keeps gate_en high for as long as no fault flag returns.
- R8: A turn-on that lasts WAIT_TICKS cycles resets the retry count to zero, so a later continuous overcurrent again takes five failed retries before locking.
- R9: While rst_n is low, gate_en and fault_alarm are low. With clear flags, gate_en first rises at the third clock edge after rst_n is released.
- R10: Undervoltage or overvoltage never raises fault_alarm. Once the flag clears, gate_en returns three clock edges after the flag was removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mreset | input | 1 | Synchronous master reset, active high |
| oc_in | input | 1 | Overcurrent or hard-short flag, asynchronous |
| uv_in | input | 1 | Undervoltage flag, asynchronous |
| ov_in | input | 1 | Overvoltage flag, asynchronous |
| limit_mode | input | 1 | 1: lock after five failed retries, 0: retry without limit |
| gate_en | output | 1 | Enable for the pass-transistor gate driver |
| fault_alarm | output | 1 | Latched alarm after the retry budget is spent |

## Verification
The hardest state to reach from the ports is a lock that comes from a stale retry count. This happens when a fault returns after a good turn-on that was too short to restore the budget. The other case is a count that was correctly cleared after four spent retries. The stimulus clears the overcurrent partway through the fifth back-off period, so the fifth retry succeeds. It then holds the gate on for longer than one period and applies a fresh continuous overcurrent. The alarm must stay low in the cycle before the full five-retry lock time and rise exactly at it. A second case holds the overcurrent through seven retries in unlimited mode and releases it inside the eighth back-off. This shows that no alarm appears at the cycle where a limited run would have locked.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ON   = 2'd1,
      ST_WAIT = 2'd2,
      ST_LOCK = 2'd3
   } hsw_state_e;

   // bit positions inside the synchronized flag vector
   localparam int unsigned FLG_OC    = 0;
   localparam int unsigned FLG_UV    = 1;
   localparam int unsigned FLG_OV    = 2;
   localparam int unsigned FLG_LIMIT = 3;
   localparam int unsigned FLG_W     = 4;

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
   parameter int unsigned       WIDTH   = 4,
   parameter int unsigned       STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hsw_tick_timer.sv
module hsw_tick_timer #(
   parameter int unsigned TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic done
);

   localparam int unsigned          CW   = (TICKS > 2) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0]        LAST = CW'(TICKS - 1);

   logic [CW-1:0] count_q;
   logic          at_end;

   assign at_end = (count_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count_q <= '0;
      else if (clr)              count_q <= '0;
      else if (run && !at_end)   count_q <= count_q + 1'b1;
   end

   assign done = at_end;

endmodule

// File: rtl/hsw_retry_fsm.sv
module hsw_retry_fsm
   import hsw_pkg::*;
#(
   parameter int unsigned MAX_RETRIES = 5,
   parameter int unsigned CNT_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mreset,
   input  logic             oc,
   input  logic             uv,
   input  logic             ov,
   input  logic             limit,
   input  logic             tmr_done,
   output logic             tmr_clr,
   output logic             tmr_run,
   output hsw_state_e       state_o,
   output logic [CNT_W-1:0] retry_cnt_o,
   output logic             gate_en,
   output logic             fault_alarm
);

   localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_RETRIES);

   hsw_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             any_fault;
   logic             budget_spent;

   assign any_fault    = oc | uv | ov;
   assign budget_spent = (cnt_q >= CAP);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (!any_fault) state_d = ST_ON;
         end
         ST_ON: begin
            if (oc) begin
               if (limit && budget_spent) state_d = ST_LOCK;
               else                       state_d = ST_WAIT;
            end else if (uv || ov) begin
               state_d = ST_IDLE;
            end else if (tmr_done) begin
               cnt_d = '0;
            end
         end
         ST_WAIT: begin
            if (tmr_done) begin
               state_d = ST_ON;
               if (!budget_spent) cnt_d = cnt_q + 1'b1;
            end
         end
         ST_LOCK: begin
            state_d = ST_LOCK;
         end
         default: state_d = ST_IDLE;
      endcase
      if (mreset) begin
         state_d = ST_IDLE;
         cnt_d   = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign tmr_clr     = mreset | (state_d != state_q);
   assign tmr_run     = (state_q == ST_ON) | (state_q == ST_WAIT);
   assign gate_en     = (state_q == ST_ON) & ~any_fault;
   assign fault_alarm = (state_q == ST_LOCK);
   assign state_o     = state_q;
   assign retry_cnt_o = cnt_q;

endmodule

// File: rtl/hsw_retry_ctrl.sv
module hsw_retry_ctrl
   import hsw_pkg::*;
#(
   parameter int unsigned WAIT_TICKS  = 10_000_000,
   parameter int unsigned MAX_RETRIES = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mreset,
   input  logic oc_in,
   input  logic uv_in,
   input  logic ov_in,
   input  logic limit_mode,
   output logic gate_en,
   output logic fault_alarm
);

   localparam int unsigned       CNT_W     = $clog2(MAX_RETRIES + 1);
   localparam logic [FLG_W-1:0]  SYNC_INIT = '1;

   if (WAIT_TICKS < 2) begin : g_chk_wait
      $error("WAIT_TICKS must be at least 2");
   end
   if (MAX_RETRIES < 1) begin : g_chk_retry
      $error("MAX_RETRIES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [FLG_W-1:0] raw_flags, sync_flags;
   logic             oc_s, uv_s, ov_s, limit_s;
   logic             tmr_clr, tmr_run, tmr_done;
   hsw_state_e       fsm_state;
   logic [CNT_W-1:0] retry_cnt;

   always_comb begin
      raw_flags            = '0;
      raw_flags[FLG_OC]    = oc_in;
      raw_flags[FLG_UV]    = uv_in;
      raw_flags[FLG_OV]    = ov_in;
      raw_flags[FLG_LIMIT] = limit_mode;
   end

   hsw_sync #(
      .WIDTH   (FLG_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_INIT)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_flags),
      .q     (sync_flags)
   );

   assign oc_s    = sync_flags[FLG_OC];
   assign uv_s    = sync_flags[FLG_UV];
   assign ov_s    = sync_flags[FLG_OV];
   assign limit_s = sync_flags[FLG_LIMIT];

   hsw_tick_timer #(
      .TICKS (WAIT_TICKS)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .run   (tmr_run),
      .done  (tmr_done)
   );

   hsw_retry_fsm #(
      .MAX_RETRIES (MAX_RETRIES),
      .CNT_W       (CNT_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .mreset      (mreset),
      .oc          (oc_s),
      .uv          (uv_s),
      .ov          (ov_s),
      .limit       (limit_s),
      .tmr_done    (tmr_done),
      .tmr_clr     (tmr_clr),
      .tmr_run     (tmr_run),
      .state_o     (fsm_state),
      .retry_cnt_o (retry_cnt),
      .gate_en     (gate_en),
      .fault_alarm (fault_alarm)
   );

endmodule

// File: rtl/hsw_retry_ctrl_chk.sv
module hsw_retry_ctrl_chk
   import hsw_pkg::*;
#(
   parameter int unsigned WAIT_TICKS  = 16,
   parameter int unsigned MAX_RETRIES = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mreset,
   input logic             oc_in,
   input logic             uv_in,
   input logic             ov_in,
   input logic             gate_en,
   input logic             fault_alarm,
   input hsw_state_e       fsm_state,
   input logic [CNT_W-1:0] retry_cnt,
   input logic             limit_s
);

   localparam int unsigned   WW    = $clog2(WAIT_TICKS + 1);
   localparam logic [WW-1:0] WLAST = WW'(WAIT_TICKS - 1);

   logic [WW-1:0] wait_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  wait_len <= '0;
      else if (fsm_state == ST_WAIT && !mreset)    wait_len <= wait_len + 1'b1;
      else                                         wait_len <= '0;
   end

   if (SYNC_STAGES == 2) begin : g_port_chk
      // R1: gate may be on only if all flags were clear two edges earlier
      a_r1_gate_needs_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
         gate_en |-> (!$past(oc_in, 2) && !$past(uv_in, 2) && !$past(ov_in, 2)));
   end

   // R2: overcurrent while on leaves the on state
   a_r2_oc_leaves_on: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_ON && $past(oc_in, 2) && !mreset) |=>
         (fsm_state == ST_WAIT || fsm_state == ST_LOCK));

   // R3: back-off holds until its last tick
   a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_WAIT && wait_len < WLAST && !mreset) |=> (fsm_state == ST_WAIT));

   // R3: back-off ends in a retry after exactly WAIT_TICKS cycles
   a_r3_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_WAIT && wait_len == WLAST && !mreset) |=> (fsm_state == ST_ON));

   // R4, R5: alarm only rises in limited mode with the budget spent
   a_r5_alarm_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_alarm) |-> ($past(limit_s) && $past(retry_cnt) == CNT_W'(MAX_RETRIES)));

   // R5: alarm is sticky and keeps the gate off
   a_r5_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_alarm && !mreset) |=> (fault_alarm && !gate_en));

   // R6: master reset clears alarm and gate at the next edge
   a_r6_mreset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      mreset |=> (!fault_alarm && !gate_en));

endmodule

bind hsw_retry_ctrl hsw_retry_ctrl_chk #(
   .WAIT_TICKS  (WAIT_TICKS),
   .MAX_RETRIES (MAX_RETRIES),
   .SYNC_STAGES (SYNC_STAGES),
   .CNT_W       (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mreset      (mreset),
   .oc_in       (oc_in),
   .uv_in       (uv_in),
   .ov_in       (ov_in),
   .gate_en     (gate_en),
   .fault_alarm (fault_alarm),
   .fsm_state   (fsm_state),
   .retry_cnt   (retry_cnt),
   .limit_s     (limit_s)
);

// File: tb/hsw_retry_ctrl_test.sv
module hsw_retry_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 16;
   localparam int LOCK_DLY   = 5 * W + 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mreset = 1'b0;
   logic oc_in = 1'b0, uv_in = 1'b0, ov_in = 1'b0;
   logic limit_mode = 1'b1;
   logic gate_en, fault_alarm;

   int cyc = 0;
   int n_checks = 0;
   int n_fails = 0;
   bit stim_done = 1'b0;

   typedef struct {
      int    at;
      bit    gate;
      bit    alarm;
      string req;
   } exp_t;

   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   hsw_retry_ctrl #(
      .WAIT_TICKS  (W),
      .MAX_RETRIES (5),
      .SYNC_STAGES (2)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .mreset      (mreset),
      .oc_in       (oc_in),
      .uv_in       (uv_in),
      .ov_in       (ov_in),
      .limit_mode  (limit_mode),
      .gate_en     (gate_en),
      .fault_alarm (fault_alarm)
   );

   task automatic expect_at(input int at, input bit g, input bit a, input string r);
      exp_t e;
      e.at = at; e.gate = g; e.alarm = a; e.req = r;
      sb.push_back(e);
   endtask

   task automatic at_cyc(input int c);
      do @(negedge clk); while (cyc < c);
   endtask

   // monitor: compares outputs at the scheduled cycle, away from the active edge
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].at <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         n_checks++;
         if (e.at < cyc) begin
            n_fails++;
            $display("FAIL %s: check for cycle %0d missed at cycle %0d", e.req, e.at, cyc);
         end else if (gate_en !== e.gate || fault_alarm !== e.alarm) begin
            n_fails++;
            $display("FAIL %s cyc %0d: gate_en=%b fault_alarm=%b expected gate_en=%b fault_alarm=%b",
                     e.req, cyc, gate_en, fault_alarm, e.gate, e.alarm);
         end
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!stim_done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: cycle %0d reached, expected end of stimulus", cyc);
         finish_run();
      end
   end

   initial begin
      // R9: reset state and first enable
      expect_at(2, 0, 0, "R9");
      expect_at(5, 0, 0, "R9");
      expect_at(6, 1, 0, "R9");
      at_cyc(3);
      rst_n = 1'b1;

      // R1, R2, R5: limited mode, continuous overcurrent from cycle 20
      expect_at(21, 1, 0, "R1");
      expect_at(22, 0, 0, "R2");
      expect_at(60, 0, 0, "R2");
      expect_at(20 + LOCK_DLY - 1, 0, 0, "R5");
      expect_at(20 + LOCK_DLY,     0, 1, "R5");
      expect_at(150, 0, 1, "R5");
      at_cyc(20);
      oc_in = 1'b1;
      at_cyc(115);
      oc_in = 1'b0;

      // R6: master reset clears the lock
      expect_at(161, 0, 0, "R6");
      expect_at(165, 0, 0, "R6");
      expect_at(166, 1, 0, "R6");
      at_cyc(160);
      mreset = 1'b1;
      at_cyc(165);
      mreset = 1'b0;

      // R3, R7: short overcurrent, one retry after exactly W cycles
      expect_at(202, 0, 0, "R1");
      expect_at(218, 0, 0, "R3");
      expect_at(219, 1, 0, "R3");
      expect_at(260, 1, 0, "R7");
      at_cyc(200);
      oc_in = 1'b1;
      at_cyc(203);
      oc_in = 1'b0;

      // R4: unlimited mode, overcurrent through seven failed retries
      expect_at(20 + LOCK_DLY + 300 - 20, 0, 0, "R4");
      expect_at(430, 0, 0, "R4");
      expect_at(437, 0, 0, "R4");
      expect_at(438, 1, 0, "R4");
      at_cyc(280);
      limit_mode = 1'b0;
      at_cyc(300);
      oc_in = 1'b1;
      at_cyc(424);
      oc_in = 1'b0;

      // R8: four spent retries, good turn-on, then a full fresh budget
      expect_at(566, 0, 0, "R8");
      expect_at(567, 1, 0, "R7");
      expect_at(590, 1, 0, "R8");
      expect_at(600 + LOCK_DLY - 1, 0, 0, "R8");
      expect_at(600 + LOCK_DLY,     0, 1, "R8");
      at_cyc(460);
      limit_mode = 1'b1;
      at_cyc(480);
      oc_in = 1'b1;
      at_cyc(553);
      oc_in = 1'b0;
      at_cyc(600);
      oc_in = 1'b1;
      at_cyc(690);
      oc_in = 1'b0;

      // R6: master reset from the lock, gate back one edge after release
      expect_at(701, 0, 0, "R6");
      expect_at(703, 1, 0, "R6");
      at_cyc(700);
      mreset = 1'b1;
      at_cyc(702);
      mreset = 1'b0;

      // R1, R10: undervoltage then overvoltage
      expect_at(721, 1, 0, "R1");
      expect_at(722, 0, 0, "R10");
      expect_at(732, 0, 0, "R10");
      expect_at(733, 1, 0, "R10");
      expect_at(752, 0, 0, "R1");
      expect_at(758, 0, 0, "R10");
      expect_at(763, 1, 0, "R10");
      expect_at(790, 1, 0, "R10");
      at_cyc(720);
      uv_in = 1'b1;
      at_cyc(730);
      uv_in = 1'b0;
      at_cyc(750);
      ov_in = 1'b1;
      at_cyc(760);
      ov_in = 1'b0;

      at_cyc(800);
      if (sb.size() != 0) begin
         n_checks++;
         n_fails++;
         $display("FAIL scoreboard: %0d checks left, expected 0", sb.size());
      end
      stim_done = 1'b1;
      finish_run();
   end

endmodule